// File: doc/BRIEF.md
# Paged Outbound Address Translator

This block turns a 32-bit local bus address into an outbound PCI Express address of 32 or 64 bits. It uses a table of equally sized pages. The low `PAGE_BITS` bits of the address are the page offset and pass straight through. The bits just above the offset pick one table entry. That entry's stored upper address bits replace everything above the offset. The local bits above the page-select field belong to the interconnect's slave decode, and the block ignores them.

Each entry also carries a 2-bit address-space type. The type says whether the result is a 32-bit address, with its upper half forced to zero, or a full 64-bit address. Two of the four codes are reserved, and a reserved code raises an error flag on the output. The table is built in one of two ways. It can be a set of run-time registers that software fills through a small word-addressed control port, typically after bus enumeration has assigned windows. Or it can be a hardwired set of constants computed from parameters. A translation takes one registered cycle, with valid/ready handshakes on the input and on the output.

Top module: `page_xlate`

## Requirements
- R1: Output bits [PAGE_BITS-1:0] equal input bits [PAGE_BITS-1:0]. For an entry of type 2'b01, output bits [OUT_AW-1:PAGE_BITS] equal the selected entry's stored address bits.
- R2: The entry index is `in_addr[PAGE_BITS+IDX_W-1:PAGE_BITS]`, where IDX_W = log2(NUM_PAGES). Input bits above that field have no effect on the result.
- R3: Type 2'b00 gives a 32-bit result: output bits [OUT_AW-1:32] are zero and `out_is64` is 0. Type 2'b01 gives the full stored address with `out_is64` = 1. For both codes, `out_err` = 0.
- R4: Type codes 2'b10 and 2'b11 are reserved. They give `out_err` = 1 and `out_is64` = 0, and the upper 32 output bits are zero.
- R5: Entry e is mapped to two control words. Word 2e is the low word: bits [31:PAGE_BITS] hold address bits [31:PAGE_BITS], bits [1:0] hold the type, and the other bits read as 0. Word 2e+1 holds address bits [63:32]. Read data appears with `cfg_rvalid` = 1 in the cycle after `cfg_rd`.
- R6: Writing a low word only stages it. Neither read-back nor translation changes until a high-word write to an entry. That write commits the high word together with the staged low word to the entry in one edge.
- R7: An input accepted at a clock edge (`in_valid` && `in_ready`) appears on the output after that edge. `in_ready` = !`out_valid` || `out_ready`. While `out_valid` && !`out_ready`, the output holds stable.
- R8: After reset, `out_valid` = 0 and every writable entry holds address 0 with type 2'b00.
- R9: With HARDWIRED = 1, entry e holds HW_BASE + e*HW_STRIDE with the low PAGE_BITS bits cleared, and type HW_TYPE. Control writes have no effect, and reads return these constants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Local address is presented |
| in_ready | output | 1 | Translator can accept an address |
| in_addr | input | 32 | Local bus address |
| out_valid | output | 1 | Translated address is valid |
| out_ready | input | 1 | Downstream takes the translated address |
| out_addr | output | OUT_AW | Translated PCI Express address |
| out_is64 | output | 1 | Result is a 64-bit address |
| out_err | output | 1 | Selected entry has a reserved type |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_rd | input | 1 | Control word read strobe |
| cfg_addr | input | IDX_W+1 | Control word index |
| cfg_wdata | input | 32 | Control write data |
| cfg_rdata | output | 32 | Control read data |
| cfg_rvalid | output | 1 | Read data valid |

## Verification
A corrupted table entry shows up in the very next translation that uses that index. It also shows in control read-back one cycle after the read strobe. So every programmed entry is checked both ways, and the bench also probes an index that was never written. A premature commit of a staged low word can be seen on the port right away: reading the low word back before the high-word write exposes it, and so does translating through that entry. A broken output register shows up as a wrong offset or a changed address while the output is stalled, within one cycle.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    typedef enum logic [1:0] {
        PGX_T32   = 2'b00,
        PGX_T64   = 2'b01,
        PGX_TRSV0 = 2'b10,
        PGX_TRSV1 = 2'b11
    } pgx_type_e;

    typedef struct packed {
        logic [1:0]  typ;
        logic [63:0] base;
    } pgx_entry_t;

endpackage

// File: rtl/pgx_table.sv
module pgx_table
    import pgx_pkg::*;
#(
    parameter int          NUM_PAGES = 16,
    parameter int          PAGE_BITS = 20,
    parameter bit          HARDWIRED = 1'b0,
    parameter logic [63:0] HW_BASE   = 64'h0000_0040_0000_0000,
    parameter logic [63:0] HW_STRIDE = 64'h0000_0000_0010_0000,
    parameter logic [1:0]  HW_TYPE   = 2'b01,
    localparam int         IDX_W     = $clog2(NUM_PAGES),
    localparam int         CFG_AW    = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              cfg_rvalid,
    input  logic [IDX_W-1:0]  lk_idx,
    output pgx_entry_t        lk_entry
);

    localparam logic [63:0] OFF_MASK = (64'd1 << PAGE_BITS) - 64'd1;

    function automatic pgx_entry_t fixed_entry(input int e);
        pgx_entry_t r;
        r.base = (HW_BASE + HW_STRIDE * 64'(e)) & ~OFF_MASK;
        r.typ  = HW_TYPE;
        return r;
    endfunction

    logic [IDX_W-1:0] cfg_idx;
    pgx_entry_t       rd_entry;

    assign cfg_idx = cfg_addr[CFG_AW-1:1];

    // Read path, shared by both table variants
    typedef struct packed {
        logic [31:0] rdata;
        logic        rvalid;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d        = rd_q;
        rd_d.rvalid = cfg_rd;
        if (cfg_rd) begin
            if (cfg_addr[0]) begin
                rd_d.rdata = rd_entry.base[63:32];
            end else begin
                rd_d.rdata = rd_entry.base[31:0] | {30'd0, rd_entry.typ};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign cfg_rdata  = rd_q.rdata;
    assign cfg_rvalid = rd_q.rvalid;

    generate
        if (HARDWIRED) begin : g_fixed
            logic unused_cfg_wr;
            assign unused_cfg_wr = ^{cfg_wr, cfg_wdata};

            always_comb begin
                lk_entry = fixed_entry(int'(lk_idx));
                rd_entry = fixed_entry(int'(cfg_idx));
            end
        end else begin : g_regs
            typedef struct packed {
                pgx_entry_t [NUM_PAGES-1:0] tbl;
                logic [31:0]                stage;
            } wr_state_t;

            wr_state_t wr_d, wr_q;

            always_comb begin
                wr_d = wr_q;
                if (cfg_wr) begin
                    if (!cfg_addr[0]) begin
                        wr_d.stage = cfg_wdata;
                    end else begin
                        wr_d.tbl[cfg_idx].base = {cfg_wdata,
                                                  wr_q.stage[31:PAGE_BITS],
                                                  {PAGE_BITS{1'b0}}};
                        wr_d.tbl[cfg_idx].typ  = wr_q.stage[1:0];
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    wr_q <= '0;
                end else begin
                    wr_q <= wr_d;
                end
            end

            always_comb begin
                lk_entry = wr_q.tbl[lk_idx];
                rd_entry = wr_q.tbl[cfg_idx];
            end
        end
    endgenerate

endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate
    import pgx_pkg::*;
#(
    parameter int PAGE_BITS = 20,
    parameter int OUT_AW    = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [PAGE_BITS-1:0] in_off,
    input  logic [63:PAGE_BITS]  up_base,
    input  logic [1:0]           typ,
    input  logic                 out_ready,
    output logic                 out_valid,
    output logic [OUT_AW-1:0]    out_addr,
    output logic                 out_is64,
    output logic                 out_err
);

    typedef struct packed {
        logic              valid;
        logic [OUT_AW-1:0] addr;
        logic              is64;
        logic              err;
    } xl_state_t;

    xl_state_t   xl_d, xl_q;
    logic [63:0] full;
    logic [63:0] narrow;

    assign full   = {up_base, in_off};
    assign narrow = {32'd0, full[31:0]};

    always_comb begin
        in_ready = !xl_q.valid || out_ready;
        xl_d     = xl_q;
        if (xl_q.valid && out_ready) begin
            xl_d.valid = 1'b0;
        end
        if (in_valid && in_ready) begin
            xl_d.valid = 1'b1;
            case (typ)
                PGX_T64: begin
                    xl_d.addr = full[OUT_AW-1:0];
                    xl_d.is64 = 1'b1;
                    xl_d.err  = 1'b0;
                end
                PGX_T32: begin
                    xl_d.addr = narrow[OUT_AW-1:0];
                    xl_d.is64 = 1'b0;
                    xl_d.err  = 1'b0;
                end
                default: begin
                    xl_d.addr = narrow[OUT_AW-1:0];
                    xl_d.is64 = 1'b0;
                    xl_d.err  = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_q <= '0;
        end else begin
            xl_q <= xl_d;
        end
    end

    assign out_valid = xl_q.valid;
    assign out_addr  = xl_q.addr;
    assign out_is64  = xl_q.is64;
    assign out_err   = xl_q.err;

endmodule

// File: rtl/page_xlate.sv
module page_xlate
    import pgx_pkg::*;
#(
    parameter int          NUM_PAGES = 16,
    parameter int          PAGE_BITS = 20,
    parameter int          OUT_AW    = 64,
    parameter bit          HARDWIRED = 1'b0,
    parameter logic [63:0] HW_BASE   = 64'h0000_0040_0000_0000,
    parameter logic [63:0] HW_STRIDE = 64'h0000_0000_0010_0000,
    parameter logic [1:0]  HW_TYPE   = 2'b01,
    localparam int         IDX_W     = $clog2(NUM_PAGES),
    localparam int         CFG_AW    = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OUT_AW-1:0] out_addr,
    output logic              out_is64,
    output logic              out_err,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              cfg_rvalid
);

    localparam int SEL_LO = PAGE_BITS + IDX_W;

    logic [IDX_W-1:0] lk_idx;
    pgx_entry_t       lk_entry;

    assign lk_idx = in_addr[SEL_LO-1:PAGE_BITS];

    // Interconnect-owned bits above the page select are not used here
    generate
        if (SEL_LO < 32) begin : g_sel
            logic unused_sel;
            assign unused_sel = ^in_addr[31:SEL_LO];
        end
    endgenerate

    logic unused_base_lo;
    assign unused_base_lo = ^lk_entry.base[PAGE_BITS-1:0];

    pgx_table #(
        .NUM_PAGES (NUM_PAGES),
        .PAGE_BITS (PAGE_BITS),
        .HARDWIRED (HARDWIRED),
        .HW_BASE   (HW_BASE),
        .HW_STRIDE (HW_STRIDE),
        .HW_TYPE   (HW_TYPE)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_rd     (cfg_rd),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cfg_rvalid (cfg_rvalid),
        .lk_idx     (lk_idx),
        .lk_entry   (lk_entry)
    );

    pgx_xlate #(
        .PAGE_BITS (PAGE_BITS),
        .OUT_AW    (OUT_AW)
    ) u_xlate (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_off    (in_addr[PAGE_BITS-1:0]),
        .up_base   (lk_entry.base[63:PAGE_BITS]),
        .typ       (lk_entry.typ),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_addr  (out_addr),
        .out_is64  (out_is64),
        .out_err   (out_err)
    );

endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
    parameter int PAGE_BITS = 20,
    parameter int OUT_AW    = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [31:0]       in_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [OUT_AW-1:0] out_addr,
    input logic              out_is64,
    input logic              out_err,
    input logic              cfg_rd,
    input logic              cfg_rvalid
);

    AST_OFFSET_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_addr[PAGE_BITS-1:0] == $past(in_addr[PAGE_BITS-1:0]))); // R1

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_is64) && $stable(out_err))); // R7

    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R7

    AST_RSV_NOT64: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> !out_is64); // R4

    AST_READ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd |=> cfg_rvalid); // R5

    generate
        if (OUT_AW > 32) begin : g_wide
            AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && !out_is64) |-> (out_addr[OUT_AW-1:32] == '0)); // R3
        end
    endgenerate

endmodule

bind page_xlate page_xlate_chk #(
    .PAGE_BITS (PAGE_BITS),
    .OUT_AW    (OUT_AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_addr    (in_addr),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_addr   (out_addr),
    .out_is64   (out_is64),
    .out_err    (out_err),
    .cfg_rd     (cfg_rd),
    .cfg_rvalid (cfg_rvalid)
);

// File: tb/page_xlate_bench.sv
module page_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        out_ready = 1'b1;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;

    logic        in_ready, out_valid, out_is64, out_err, cfg_rvalid;
    logic [63:0] out_addr;
    logic [31:0] cfg_rdata;

    logic        hw_in_ready, hw_out_valid, hw_out_is64, hw_out_err, hw_cfg_rvalid;
    logic [63:0] hw_out_addr;
    logic [31:0] hw_cfg_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    page_xlate u_page_xlate (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_is64(out_is64), .out_err(out_err),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid)
    );

    page_xlate #(.HARDWIRED(1'b1)) u_page_xlate_hw (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(hw_in_ready),
        .in_addr(in_addr), .out_valid(hw_out_valid), .out_ready(out_ready),
        .out_addr(hw_out_addr), .out_is64(hw_out_is64), .out_err(hw_out_err),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(hw_cfg_rdata), .cfg_rvalid(hw_cfg_rvalid)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [63:0] x;
        logic        is64;
        logic        err;
    } vec_t;

    // Entry 0: type 01 base 12345678_9AB00000; entry 3: type 00;
    // entry 15: type 01; entry 7: reserved type 10; entry 5 never written.
    localparam vec_t VECS [6] = '{
        '{32'h0000_1234, 64'h1234_5678_9AB0_1234, 1'b1, 1'b0},  // R1
        '{32'hAB0F_FFFF, 64'h1234_5678_9ABF_FFFF, 1'b1, 1'b0},  // R2
        '{32'h0030_0ABC, 64'h0000_0000_CDE0_0ABC, 1'b0, 1'b0},  // R3
        '{32'hFFFF_FFFF, 64'hFEDC_BA98_765F_FFFF, 1'b1, 1'b0},  // R2
        '{32'h0070_0005, 64'h0000_0000_0010_0005, 1'b0, 1'b1},  // R4
        '{32'h0050_0001, 64'h0000_0000_0000_0001, 1'b0, 1'b0}   // R8
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [4:0] a, output logic [31:0] d,
                            output logic [31:0] hd, output logic v);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_addr = a;
        @(negedge clk);
        cfg_rd = 1'b0;
        d = cfg_rdata; hd = hw_cfg_rdata; v = cfg_rvalid;
    endtask

    task automatic xlate(input logic [31:0] a);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R7 watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd, hrd;
        logic        rv;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        chk("R8 out_valid after reset", 64'(out_valid), 64'd0);
        chk("R7 in_ready when idle", 64'(in_ready), 64'd1);
        cfg_read(5'd4, rd, hrd, rv);
        chk("R5 rvalid after read", 64'(rv), 64'd1);
        chk("R8 entry2 low after reset", 64'(rd), 64'd0);
        chk("R9 hardwired entry2 low", 64'(hrd), 64'h0020_0001);
        cfg_read(5'd5, rd, hrd, rv);
        chk("R8 entry2 high after reset", 64'(rd), 64'd0);
        chk("R9 hardwired entry2 high", 64'(hrd), 64'h0000_0040);
        xlate(32'h0020_0123);
        chk("R8 zero entry translation", out_addr, 64'h0000_0000_0000_0123);
        chk("R8 zero entry is 32-bit", 64'(out_is64), 64'd0);
        chk("R9 hardwired translation", hw_out_addr, 64'h0000_0040_0020_0123);
        chk("R9 hardwired is64", 64'(hw_out_is64), 64'd1);

        // Program table (low word carries junk in bits [19:2] for entry 0)
        cfg_write(5'd0,  32'h9AB7_FFFD); cfg_write(5'd1,  32'h1234_5678);
        cfg_write(5'd6,  32'hCDE0_0000); cfg_write(5'd7,  32'hFFFF_FFFF);
        cfg_write(5'd30, 32'h7650_0001); cfg_write(5'd31, 32'hFEDC_BA98);
        cfg_write(5'd14, 32'h0010_0002); cfg_write(5'd15, 32'h0000_0001);

        for (int i = 0; i < 6; i++) begin
            xlate(VECS[i].a);
            chk($sformatf("R1 R2 R3 R4 vec%0d valid", i), 64'(out_valid), 64'd1);
            chk($sformatf("R1 R2 R3 vec%0d addr", i), out_addr, VECS[i].x);
            chk($sformatf("R3 vec%0d is64", i), 64'(out_is64), 64'(VECS[i].is64));
            chk($sformatf("R4 vec%0d err", i), 64'(out_err), 64'(VECS[i].err));
        end

        // R5 read-back: reserved bits read zero
        cfg_read(5'd0, rd, hrd, rv);
        chk("R5 entry0 low readback", 64'(rd), 64'h9AB0_0001);
        cfg_read(5'd1, rd, hrd, rv);
        chk("R5 entry0 high readback", 64'(rd), 64'h1234_5678);

        // R6 staged low word has no effect until the high write
        cfg_write(5'd2, 32'h5550_0001);
        cfg_read(5'd2, rd, hrd, rv);
        chk("R6 low staged not visible", 64'(rd), 64'd0);
        xlate(32'h0010_0042);
        chk("R6 translation before commit", out_addr, 64'h0000_0000_0000_0042);
        chk("R6 type before commit", 64'(out_is64), 64'd0);
        cfg_write(5'd3, 32'h0000_0777);
        cfg_read(5'd2, rd, hrd, rv);
        chk("R6 low after commit", 64'(rd), 64'h5550_0001);
        xlate(32'h0010_0042);
        chk("R6 translation after commit", out_addr, 64'h0000_0777_5550_0042);

        // R9 writes ignored in hardwired mode
        cfg_write(5'd4, 32'hAAA0_0000); cfg_write(5'd5, 32'hBBBB_BBBB);
        xlate(32'h0020_0123);
        chk("R9 hardwired after write", hw_out_addr, 64'h0000_0040_0020_0123);
        chk("R6 writable entry2 committed", out_addr, 64'h0000_0000_AAA0_0123);
        cfg_read(5'd5, rd, hrd, rv);
        chk("R9 hardwired high after write", 64'(hrd), 64'h0000_0040);

        // R7 stall: output holds, second address waits
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; in_addr = 32'h0000_0010;
        @(negedge clk);
        chk("R7 one-cycle latency", 64'(out_valid), 64'd1);
        chk("R7 first addr", out_addr, 64'h1234_5678_9AB0_0010);
        chk("R7 ready low when stalled", 64'(in_ready), 64'd0);
        in_addr = 32'h00F0_0020;
        @(negedge clk);
        @(negedge clk);
        chk("R7 held while stalled", out_addr, 64'h1234_5678_9AB0_0010);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7 second addr after release", out_addr, 64'hFEDC_BA98_7650_0020);
        chk("R7 second valid", 64'(out_valid), 64'd1);
        @(negedge clk);
        chk("R7 drained", 64'(out_valid), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule